// File: doc/BRIEF.md
# CANopen automatic acknowledge generator

This block answers each correctly received fragment of a segmented CANopen transfer with an acknowledge frame. The CPU takes no part. When receive object `n` reports a good frame, the block queues a transmit request for the next object, `n+1`. That request carries the acknowledge byte stored for object `n+1`, with the toggle bit of the received frame written into the toggle bit position. It also carries the identifier, remote flag and length code that are configured for object `n+1`, unchanged.

Three conditions gate the reply:
- the global acknowledge enable is set;
- the protocol select reads CANopen;
- both objects of the pair are marked as fragmented, and the partner is not enabled as an ordinary transmit object.

A request stays pending until the transmitter accepts it. A further qualifying reception that arrives while a request is still pending is reported as an overrun, and that reception is dropped.

Top module: `canopen_ack_gen`

## Requirements
- R1: After reset `tx_req_o` and `ack_ovr_o` are 0.
- R2: A reply is produced only when `ack_en_i` is 1 and `proto_sel_i` equals 2'b10 (CANopen). The codes 2'b00, 2'b01 and 2'b11 never produce a reply.
- R3: A reception on object `n` produces a reply only if `frag_en_i[n]` is 1.
- R4: A reply also requires `frag_en_i[n+1]` to be 1 and `obj_en_i[n+1]` to be 0.
- R5: One cycle after a qualifying `rx_done_i` strobe, `tx_req_o` is 1 and `tx_obj_o` equals `n+1`. At the same time `tx_id_o`, `tx_rtr_o` and `tx_dlc_o` equal the slices of `obj_id_i`, `obj_rtr_i` and `obj_dlc_i` for object `n+1`.
- R6: `tx_data0_o` equals byte `n+1` of `ack_byte_i` (bits [8(n+1)+7 : 8(n+1)]), except that bit 4 equals the `rx_toggle_i` value sampled with the strobe.
- R7: A strobe with `rx_frag_err_i` = 1 produces no reply.
- R8: Receive object 31, the highest object, never produces a reply.
- R9: `tx_req_o` stays at 1 with stable contents until a cycle in which `tx_accept_i` is 1. It is 0 in the following cycle unless a new reply was loaded in that same cycle.
- R10: A qualifying strobe while a request is pending and `tx_accept_i` is 0 makes `ack_ovr_o` 1 for exactly one cycle and leaves the pending request unchanged. A qualifying strobe in the same cycle as an accept loads the new reply instead, with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_en_i | input | 1 | Global automatic acknowledge enable |
| proto_sel_i | input | 2 | System protocol select, 2'b10 = CANopen |
| frag_en_i | input | 32 | Per-object fragmentation enable |
| obj_en_i | input | 32 | Per-object ordinary enable |
| ack_byte_i | input | 256 | Stored acknowledge byte per object, object k at [8k+7:8k] |
| obj_id_i | input | 928 | Identifier per object, object k at [29k+28:29k] |
| obj_rtr_i | input | 32 | Remote request flag per object |
| obj_dlc_i | input | 128 | Data length code per object, object k at [4k+3:4k] |
| rx_done_i | input | 1 | One-cycle strobe: a frame finished on object `rx_obj_i` |
| rx_frag_err_i | input | 1 | Qualifier of the strobe: fragmentation error |
| rx_obj_i | input | 5 | Receive object number |
| rx_toggle_i | input | 1 | Toggle bit of the received frame |
| tx_accept_i | input | 1 | Transmitter takes the pending request |
| tx_req_o | output | 1 | Acknowledge transmit request pending |
| tx_obj_o | output | 5 | Transmit object number (n+1) |
| tx_data0_o | output | 8 | First data byte of the reply |
| tx_id_o | output | 29 | Identifier of the reply |
| tx_rtr_o | output | 1 | Remote flag of the reply |
| tx_dlc_o | output | 4 | Length code of the reply |
| ack_ovr_o | output | 1 | One-cycle pulse: a reply was lost to a pending request |

## Verification
The internal state of the block is a single pending flag plus the frame fields captured when a reply is loaded. Every part of that state is visible on the outputs one clock after the qualifying strobe. A wrong gate decision shows up as `tx_req_o` rising, or failing to rise, in the cycle after the strobe. A wrong partner index or a bad toggle merge shows up in `tx_obj_o` or `tx_data0_o` in that same cycle. A pending flag that is lost or stuck shows up either as `tx_req_o` dropping before an accept or staying high after one, or as a missing or spurious `ack_ovr_o` pulse on the second strobe.

// File: rtl/canack_pkg.sv
package canack_pkg;
  typedef enum logic [1:0] {
    PROTO_CAN     = 2'b00,
    PROTO_RSVD_A  = 2'b01,
    PROTO_CANOPEN = 2'b10,
    PROTO_RSVD_B  = 2'b11
  } proto_e;
endpackage

// File: rtl/ack_qualify.sv
// Decides whether a finished reception earns an acknowledge and names the partner.
module ack_qualify #(
  parameter int NUM_OBJ = 32,
  parameter int OBJ_W   = $clog2(NUM_OBJ)
) (
  input  logic               ack_en_i,
  input  logic [1:0]         proto_sel_i,
  input  logic [NUM_OBJ-1:0] frag_en_i,
  input  logic [NUM_OBJ-1:0] obj_en_i,
  input  logic               rx_done_i,
  input  logic               rx_frag_err_i,
  input  logic [OBJ_W-1:0]   rx_obj_i,
  output logic               fire_o,
  output logic [OBJ_W-1:0]   partner_o
);
  import canack_pkg::*;

  localparam logic [OBJ_W:0] LAST_OBJ = (OBJ_W+1)'(NUM_OBJ - 1);

  logic has_partner;
  logic proto_ok;
  logic pair_ok;

  always_comb begin
    has_partner = ({1'b0, rx_obj_i} < LAST_OBJ);
    partner_o   = rx_obj_i + OBJ_W'(1);
    proto_ok    = ack_en_i && (proto_sel_i == PROTO_CANOPEN);
    pair_ok     = 1'b0;
    if (has_partner) begin
      pair_ok = frag_en_i[rx_obj_i] && frag_en_i[partner_o] && !obj_en_i[partner_o];
    end
    fire_o = rx_done_i && !rx_frag_err_i && proto_ok && pair_ok;
  end
endmodule

// File: rtl/ack_frame_sel.sv
// Selects the partner's stored fields and merges the received toggle into the data byte.
module ack_frame_sel #(
  parameter int NUM_OBJ    = 32,
  parameter int OBJ_W      = $clog2(NUM_OBJ),
  parameter int DATA_W     = 8,
  parameter int ID_W       = 29,
  parameter int DLC_W      = 4,
  parameter int TOGGLE_BIT = 4
) (
  input  logic [OBJ_W-1:0]          partner_i,
  input  logic                      toggle_i,
  input  logic [NUM_OBJ*DATA_W-1:0] ack_byte_i,
  input  logic [NUM_OBJ*ID_W-1:0]   obj_id_i,
  input  logic [NUM_OBJ-1:0]        obj_rtr_i,
  input  logic [NUM_OBJ*DLC_W-1:0]  obj_dlc_i,
  output logic [DATA_W-1:0]         data_o,
  output logic [ID_W-1:0]           id_o,
  output logic                      rtr_o,
  output logic [DLC_W-1:0]          dlc_o
);
  logic [DATA_W-1:0] stored_byte;

  always_comb begin
    stored_byte = ack_byte_i[partner_i*DATA_W +: DATA_W];
    id_o        = obj_id_i[partner_i*ID_W +: ID_W];
    rtr_o       = obj_rtr_i[partner_i];
    dlc_o       = obj_dlc_i[partner_i*DLC_W +: DLC_W];
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == TOGGLE_BIT) begin : g_tog
      assign data_o[b] = toggle_i;
    end else begin : g_keep
      assign data_o[b] = stored_byte[b];
    end
  end
endmodule

// File: rtl/ack_req_hold.sv
// Holds one pending acknowledge request and flags replies lost to a busy slot.
module ack_req_hold #(
  parameter int OBJ_W  = 5,
  parameter int DATA_W = 8,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              accept_i,
  input  logic [OBJ_W-1:0]  obj_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              rtr_i,
  input  logic [DLC_W-1:0]  dlc_i,
  output logic              req_o,
  output logic [OBJ_W-1:0]  obj_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ID_W-1:0]   id_o,
  output logic              rtr_o,
  output logic [DLC_W-1:0]  dlc_o,
  output logic              ovr_o
);
  logic pend_q, pend_d;
  logic ovr_q, ovr_d;
  logic slot_free;
  logic load_en;

  // next-state
  always_comb begin
    slot_free = !pend_q || accept_i;
    load_en   = fire_i && slot_free;
    pend_d    = load_en || (pend_q && !accept_i);
    ovr_d     = fire_i && !slot_free;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  // captured frame fields, clock-enabled by load_en
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obj_o  <= '0;
      data_o <= '0;
      id_o   <= '0;
      rtr_o  <= 1'b0;
      dlc_o  <= '0;
    end else if (load_en) begin
      obj_o  <= obj_i;
      data_o <= data_i;
      id_o   <= id_i;
      rtr_o  <= rtr_i;
      dlc_o  <= dlc_i;
    end
  end

  assign req_o = pend_q;
  assign ovr_o = ovr_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !accept_i) |=> (pend_q && $stable(obj_o) && $stable(data_o) && $stable(id_o)));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && accept_i && !fire_i) |=> !pend_q);

  // R10
  ovr_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> ($past(pend_q) && $past(fire_i) && !$past(accept_i)));
endmodule

// File: rtl/canopen_ack_gen.sv
module canopen_ack_gen #(
  parameter int NUM_OBJ    = 32,
  parameter int DATA_W     = 8,
  parameter int ID_W       = 29,
  parameter int DLC_W      = 4,
  parameter int TOGGLE_BIT = 4,
  localparam int OBJ_W     = $clog2(NUM_OBJ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_en_i,
  input  logic [1:0]                proto_sel_i,
  input  logic [NUM_OBJ-1:0]        frag_en_i,
  input  logic [NUM_OBJ-1:0]        obj_en_i,
  input  logic [NUM_OBJ*DATA_W-1:0] ack_byte_i,
  input  logic [NUM_OBJ*ID_W-1:0]   obj_id_i,
  input  logic [NUM_OBJ-1:0]        obj_rtr_i,
  input  logic [NUM_OBJ*DLC_W-1:0]  obj_dlc_i,
  input  logic                      rx_done_i,
  input  logic                      rx_frag_err_i,
  input  logic [OBJ_W-1:0]          rx_obj_i,
  input  logic                      rx_toggle_i,
  input  logic                      tx_accept_i,
  output logic                      tx_req_o,
  output logic [OBJ_W-1:0]          tx_obj_o,
  output logic [DATA_W-1:0]         tx_data0_o,
  output logic [ID_W-1:0]           tx_id_o,
  output logic                      tx_rtr_o,
  output logic [DLC_W-1:0]          tx_dlc_o,
  output logic                      ack_ovr_o
);
  import canack_pkg::*;

  logic              fire;
  logic [OBJ_W-1:0]  partner;
  logic [DATA_W-1:0] sel_data;
  logic [ID_W-1:0]   sel_id;
  logic              sel_rtr;
  logic [DLC_W-1:0]  sel_dlc;

  ack_qualify #(.NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W)) u_qual (
    .ack_en_i     (ack_en_i),
    .proto_sel_i  (proto_sel_i),
    .frag_en_i    (frag_en_i),
    .obj_en_i     (obj_en_i),
    .rx_done_i    (rx_done_i),
    .rx_frag_err_i(rx_frag_err_i),
    .rx_obj_i     (rx_obj_i),
    .fire_o       (fire),
    .partner_o    (partner)
  );

  ack_frame_sel #(
    .NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W), .DATA_W(DATA_W),
    .ID_W(ID_W), .DLC_W(DLC_W), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_sel (
    .partner_i (partner),
    .toggle_i  (rx_toggle_i),
    .ack_byte_i(ack_byte_i),
    .obj_id_i  (obj_id_i),
    .obj_rtr_i (obj_rtr_i),
    .obj_dlc_i (obj_dlc_i),
    .data_o    (sel_data),
    .id_o      (sel_id),
    .rtr_o     (sel_rtr),
    .dlc_o     (sel_dlc)
  );

  ack_req_hold #(.OBJ_W(OBJ_W), .DATA_W(DATA_W), .ID_W(ID_W), .DLC_W(DLC_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .accept_i(tx_accept_i),
    .obj_i   (partner),
    .data_i  (sel_data),
    .id_i    (sel_id),
    .rtr_i   (sel_rtr),
    .dlc_i   (sel_dlc),
    .req_o   (tx_req_o),
    .obj_o   (tx_obj_o),
    .data_o  (tx_data0_o),
    .id_o    (tx_id_o),
    .rtr_o   (tx_rtr_o),
    .dlc_o   (tx_dlc_o),
    .ovr_o   (ack_ovr_o)
  );

  // R2 R7
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_o) |-> $past(ack_en_i && (proto_sel_i == PROTO_CANOPEN)
                              && rx_done_i && !rx_frag_err_i));

  // R6
  toggle_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_o) |-> (tx_data0_o[TOGGLE_BIT] == $past(rx_toggle_i)));

  // R5 R8
  partner_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> (tx_obj_o != '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!tx_req_o && !ack_ovr_o));
endmodule

// File: tb/canopen_ack_gen_test.sv
module canopen_ack_gen_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ack_en_i;
  logic [1:0]    proto_sel_i;
  logic [N-1:0]  frag_en_i;
  logic [N-1:0]  obj_en_i;
  logic [N*8-1:0]  ack_byte_i;
  logic [N*29-1:0] obj_id_i;
  logic [N-1:0]    obj_rtr_i;
  logic [N*4-1:0]  obj_dlc_i;
  logic          rx_done_i;
  logic          rx_frag_err_i;
  logic [4:0]    rx_obj_i;
  logic          rx_toggle_i;
  logic          tx_accept_i;
  logic          tx_req_o;
  logic [4:0]    tx_obj_o;
  logic [7:0]    tx_data0_o;
  logic [28:0]   tx_id_o;
  logic          tx_rtr_o;
  logic [3:0]    tx_dlc_o;
  logic          ack_ovr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  canopen_ack_gen uut (.*);

  always #4 clk = ~clk;

  function automatic logic [7:0] byte_of(int k);
    return 8'h5A ^ 8'(k * 7);
  endfunction
  function automatic logic [28:0] id_of(int k);
    return 29'h0ABC000 + 29'(k * 13);
  endfunction
  function automatic logic [3:0] dlc_of(int k);
    return 4'(k % 9);
  endfunction
  function automatic logic [7:0] merged(int k, logic tog);
    logic [7:0] b;
    b = byte_of(k);
    b[4] = tog;
    return b;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic default_cfg();
    ack_en_i = 1'b1;
    proto_sel_i = 2'b10;
    frag_en_i = '1;
    obj_en_i = '0;
  endtask

  // Drive one strobe between negedges; on return the output reflects it.
  task automatic strobe(input int n, input logic tog, input logic err);
    rx_done_i = 1'b1;
    rx_obj_i = 5'(n);
    rx_toggle_i = tog;
    rx_frag_err_i = err;
    @(negedge clk);
    rx_done_i = 1'b0;
    rx_frag_err_i = 1'b0;
  endtask

  task automatic accept();
    tx_accept_i = 1'b1;
    @(negedge clk);
    tx_accept_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(32'(tx_req_o), 0, "R1 req");
    chk(32'(ack_ovr_o), 0, "R1 ovr");
  endtask

  task automatic t_basic();
    default_cfg();
    strobe(3, 1'b1, 1'b0);
    chk(32'(tx_req_o), 1, "R5 req");
    chk(32'(tx_obj_o), 4, "R5 obj");
    chk(32'(tx_id_o), 32'(id_of(4)), "R5 id");
    chk(32'(tx_rtr_o), 0, "R5 rtr");
    chk(32'(tx_dlc_o), 32'(dlc_of(4)), "R5 dlc");
    chk(32'(tx_data0_o), 32'(merged(4, 1'b1)), "R6 data tog1");
    accept();
    chk(32'(tx_req_o), 0, "R9 cleared after accept");
    strobe(10, 1'b0, 1'b0);
    chk(32'(tx_data0_o), 32'(merged(11, 1'b0)), "R6 data tog0");
    chk(32'(tx_rtr_o), 1, "R5 rtr obj11");
    accept();
  endtask

  task automatic t_hold();
    strobe(5, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(32'(tx_req_o), 1, "R9 held");
    chk(32'(tx_obj_o), 6, "R9 obj stable");
    accept();
    chk(32'(tx_req_o), 0, "R9 released");
  endtask

  task automatic t_gate();
    ack_en_i = 1'b0;
    strobe(2, 1'b1, 1'b0);
    chk(32'(tx_req_o), 0, "R2 global enable off");
    ack_en_i = 1'b1;
    for (int p = 0; p < 4; p++) begin
      if (p != 2) begin
        proto_sel_i = 2'(p);
        strobe(2, 1'b1, 1'b0);
        chk(32'(tx_req_o), 0, "R2 non-CANopen protocol");
      end
    end
    default_cfg();
  endtask

  task automatic t_frag();
    frag_en_i[7] = 1'b0;
    strobe(7, 1'b0, 1'b0);
    chk(32'(tx_req_o), 0, "R3 rx frag off");
    default_cfg();
    frag_en_i[9] = 1'b0;
    strobe(8, 1'b0, 1'b0);
    chk(32'(tx_req_o), 0, "R4 partner frag off");
    default_cfg();
    obj_en_i[12] = 1'b1;
    strobe(11, 1'b0, 1'b0);
    chk(32'(tx_req_o), 0, "R4 partner enabled");
    default_cfg();
  endtask

  task automatic t_err();
    strobe(2, 1'b1, 1'b1);
    chk(32'(tx_req_o), 0, "R7 frag error");
  endtask

  task automatic t_last();
    strobe(31, 1'b1, 1'b0);
    chk(32'(tx_req_o), 0, "R8 last object");
    strobe(30, 1'b1, 1'b0);
    chk(32'(tx_req_o), 1, "R8 neighbour replies");
    chk(32'(tx_obj_o), 31, "R5 obj31");
    accept();
  endtask

  task automatic t_overrun();
    strobe(1, 1'b0, 1'b0);
    strobe(20, 1'b1, 1'b0);
    chk(32'(ack_ovr_o), 1, "R10 overrun pulse");
    chk(32'(tx_obj_o), 2, "R10 pending kept");
    chk(32'(tx_data0_o), 32'(merged(2, 1'b0)), "R10 data kept");
    @(negedge clk);
    chk(32'(ack_ovr_o), 0, "R10 pulse one cycle");
    accept();
    strobe(4, 1'b0, 1'b0);
    tx_accept_i = 1'b1;
    strobe(6, 1'b1, 1'b0);
    tx_accept_i = 1'b0;
    chk(32'(tx_req_o), 1, "R10 reload on accept");
    chk(32'(tx_obj_o), 7, "R10 reload obj");
    chk(32'(ack_ovr_o), 0, "R10 no overrun on accept");
    accept();
    chk(32'(tx_req_o), 0, "R9 final clear");
  endtask

  initial begin
    rst_n = 1'b0;
    ack_en_i = 1'b0;
    proto_sel_i = 2'b00;
    frag_en_i = '0;
    obj_en_i = '0;
    rx_done_i = 1'b0;
    rx_frag_err_i = 1'b0;
    rx_obj_i = '0;
    rx_toggle_i = 1'b0;
    tx_accept_i = 1'b0;
    for (int k = 0; k < N; k++) begin
      ack_byte_i[k*8 +: 8] = byte_of(k);
      obj_id_i[k*29 +: 29] = id_of(k);
      obj_rtr_i[k] = k[0];
      obj_dlc_i[k*4 +: 4] = dlc_of(k);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_gate();
    t_frag();
    t_err();
    t_last();
    t_overrun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule